// File: doc/BRIEF.md
# Register-File ALU Memory Datapath

This block is the execute path of a small processor. It holds four general registers, two of which can be read at the same time. The two values go into an arithmetic/logic unit, and the unit reports signed overflow, carry, negative and zero beside its result. The same two values also reach a data memory. The first read value is the memory address and the second is the data to store, so memory traffic always passes through the register file and the unit never touches memory directly.

A source select decides what goes back into the register file on a write: the unit's result or the word the memory returns. A control unit outside the block drives these inputs every cycle:

- the three register addresses,
- the register write enable,
- the operation code,
- the memory write enable,
- the writeback source select.

Every access completes in one cycle. Register reads and memory reads are combinational. Register and memory writes take effect at the rising clock edge.

The data width `W` is a parameter. The memory holds 2^W words of `W` bits, because a register value is its address.

Top module: `regalu_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four registers to zero.
- R2: At a rising edge with `reg_we` = 1, register `dst_sel` takes `wb_data`. With `reg_we` = 0, no register changes.
- R3: `rd_a` shows register `src_a_sel` and `rd_b` shows register `src_b_sel`, combinationally. The two ports are independent and may name the same register.
- R4: When a register is read and written in the same cycle, the read shows the old value in that cycle and the new value after the edge.
- R5: Arithmetic op codes use an adder on (x, y, carry-in): 0 = A, 1 = A+1, 2 = A+B, 3 = A+B+1, 4 = A+~B, 5 = A+~B+1, 6 = A-1 (A plus all ones). For these codes, `flag_c` is the adder carry out and `flag_v` is set when x and y have the same sign and the result sign differs.
- R6: Non-adder op codes clear `flag_c` and `flag_v`: 7 = B, 8 = A&B, 9 = A|B, 10 = A^B, 11 = ~A, 12 = B logical shift right by one, 13 = B shift left by one.
- R7: For op codes 0 to 13, `flag_n` equals the result MSB and `flag_z` is 1 exactly when the result is zero.
- R8: Op codes 14 to 31 give a zero result with all four flags cleared, `flag_z` included.
- R9: At a rising edge with `mem_we` = 1, the memory word addressed by `rd_a` takes `rd_b`. With `mem_we` = 0, memory is unchanged. Memory reads are combinational at address `rd_a`.
- R10: `wb_data` is the ALU result when `wb_from_mem` = 0 and the memory word at `rd_a` when `wb_from_mem` = 1.
- R11: Reset does not alter memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the registers, active high |
| dst_sel | input | 2 | Register written on `reg_we` |
| src_a_sel | input | 2 | Register on read port A (ALU A, memory address) |
| src_b_sel | input | 2 | Register on read port B (ALU B, memory store data) |
| reg_we | input | 1 | Register write enable |
| alu_op | input | 5 | Operation code |
| mem_we | input | 1 | Memory write enable |
| wb_from_mem | input | 1 | Writeback source: 0 ALU, 1 memory |
| rd_a | output | W | Read port A value |
| rd_b | output | W | Read port B value |
| alu_res | output | W | ALU result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| wb_data | output | W | Value offered to the register file |

## Verification
The bench aims at the flag edges that a careless adder gets wrong:
- overflow on 0x7F+1 and on 0x80-1, where a design that tests the wrong operand signs would stay silent;
- the borrow-style carry of a subtract, where a design using true borrow would invert C;
- decrement of zero;
- unused codes, where Z must stay clear even though the result is zero.

It also checks read-during-write. A write-through register file would show the new value a cycle early. It checks that a memory store lands only at the address taken from port A and survives a reset, which a design that resets the memory or swaps address and data would break. Finally, it checks that a disabled register write leaves the target untouched.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_PASS_A   = 5'd0,
        OP_INC_A    = 5'd1,
        OP_ADD      = 5'd2,
        OP_ADD_INC  = 5'd3,
        OP_ADD_NOTB = 5'd4,
        OP_SUB      = 5'd5,
        OP_DEC_A    = 5'd6,
        OP_PASS_B   = 5'd7,
        OP_AND      = 5'd8,
        OP_OR       = 5'd9,
        OP_XOR      = 5'd10,
        OP_NOT_A    = 5'd11,
        OP_SHR_B    = 5'd12,
        OP_SHL_B    = 5'd13
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST_VALID = 5'd13;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } alu_flags_t;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int W     = 8,
    parameter int NREGS = 4,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_a_addr,
    input  logic [AW-1:0] rd_b_addr,
    output logic [W-1:0]  rd_a_data,
    output logic [W-1:0]  rd_b_data
);

    typedef struct packed {
        logic [NREGS-1:0][W-1:0] regs;
    } rf_state_t;

    rf_state_t        st_d, st_q;
    logic [NREGS-1:0] load_en;

    // write decoder, gated by the enable
    for (genvar i = 0; i < NREGS; i++) begin : g_dec
        assign load_en[i] = wr_en && (wr_addr == AW'(i));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREGS; i++) begin
            if (load_en[i]) begin
                st_d.regs[i] = wr_data;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // reads see the registered state only: old value during a write
    assign rd_a_data = st_q.regs[rd_a_addr];
    assign rd_b_data = st_q.regs[rd_b_addr];

    // R1: reset clears every register
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.regs == '0));

    // R2: an enabled write lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q.regs[$past(wr_addr)] == $past(wr_data)));

    // R2: no write enable, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q.regs));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    f,
    output alu_flags_t      flags
);

    logic [W-1:0] add_x, add_y, logic_res;
    logic         add_cin, is_arith, is_valid;
    logic [W:0]   sum;

    always_comb begin
        add_x     = '0;
        add_y     = '0;
        add_cin   = 1'b0;
        logic_res = '0;
        is_arith  = 1'b0;
        is_valid  = 1'b1;
        case (op)
            OP_PASS_A:   begin is_arith = 1'b1; add_x = a; end
            OP_INC_A:    begin is_arith = 1'b1; add_x = a; add_cin = 1'b1; end
            OP_ADD:      begin is_arith = 1'b1; add_x = a; add_y = b; end
            OP_ADD_INC:  begin is_arith = 1'b1; add_x = a; add_y = b; add_cin = 1'b1; end
            OP_ADD_NOTB: begin is_arith = 1'b1; add_x = a; add_y = ~b; end
            OP_SUB:      begin is_arith = 1'b1; add_x = a; add_y = ~b; add_cin = 1'b1; end
            OP_DEC_A:    begin is_arith = 1'b1; add_x = a; add_y = '1; end
            OP_PASS_B:   logic_res = b;
            OP_AND:      logic_res = a & b;
            OP_OR:       logic_res = a | b;
            OP_XOR:      logic_res = a ^ b;
            OP_NOT_A:    logic_res = ~a;
            OP_SHR_B:    logic_res = b >> 1;
            OP_SHL_B:    logic_res = b << 1;
            default:     is_valid = 1'b0;
        endcase

        sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};

        if (!is_valid) begin
            f = '0;
        end else if (is_arith) begin
            f = sum[W-1:0];
        end else begin
            f = logic_res;
        end

        flags.c = is_arith & sum[W];
        flags.v = is_arith & (add_x[W-1] == add_y[W-1]) & (sum[W-1] != add_x[W-1]);
        flags.n = is_valid & f[W-1];
        flags.z = is_valid & (f == '0);
    end

endmodule

// File: rtl/dp_dmem.sv
module dp_dmem #(
    parameter int W      = 8,
    localparam int DEPTH = 1 << W
) (
    input  logic         clk,
    input  logic         we,
    input  logic [W-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] words;
    } mem_state_t;

    mem_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.words[addr] = wdata;
        end
    end

    // no reset: contents persist across register reset
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.words[addr];

    // R9: a store lands at the address from read port A
    a_r9_store_lands: assert property (@(posedge clk)
        we |=> (st_q.words[$past(addr)] == $past(wdata)));

    // R9: no store, no change
    a_r9_no_store_hold: assert property (@(posedge clk)
        (we == 1'b0) |=> $stable(st_q.words));

endmodule

// File: rtl/regalu_datapath.sv
module regalu_datapath
    import dp_pkg::*;
#(
    parameter int W      = 8,
    parameter int NREGS  = 4,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   dst_sel,
    input  logic [AW-1:0]   src_a_sel,
    input  logic [AW-1:0]   src_b_sel,
    input  logic            reg_we,
    input  logic [OP_W-1:0] alu_op,
    input  logic            mem_we,
    input  logic            wb_from_mem,
    output logic [W-1:0]    rd_a,
    output logic [W-1:0]    rd_b,
    output logic [W-1:0]    alu_res,
    output logic            flag_v,
    output logic            flag_c,
    output logic            flag_n,
    output logic            flag_z,
    output logic [W-1:0]    wb_data
);

    logic [W-1:0] mem_rdata;
    alu_flags_t   flags;

    dp_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_we),
        .wr_addr   (dst_sel),
        .wr_data   (wb_data),
        .rd_a_addr (src_a_sel),
        .rd_b_addr (src_b_sel),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b)
    );

    dp_alu #(.W(W)) u_alu (
        .a     (rd_a),
        .b     (rd_b),
        .op    (alu_op),
        .f     (alu_res),
        .flags (flags)
    );

    dp_dmem #(.W(W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (rd_a),
        .wdata (rd_b),
        .rdata (mem_rdata)
    );

    // writeback source select
    always_comb begin
        wb_data = wb_from_mem ? mem_rdata : alu_res;
    end

    assign flag_v = flags.v;
    assign flag_c = flags.c;
    assign flag_n = flags.n;
    assign flag_z = flags.z;

    // R7: zero flag only with a zero result
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
        flag_z |-> (alu_res == '0));

    // R7: negative flag only with the MSB set
    a_r7_neg_flag: assert property (@(posedge clk) disable iff (rst)
        flag_n |-> alu_res[W-1]);

    // R8: unused codes give zero and no flags
    a_r8_unused_clear: assert property (@(posedge clk) disable iff (rst)
        (alu_op > OP_LAST_VALID) |-> (alu_res == '0 && !flag_v && !flag_c && !flag_n && !flag_z));

    // R6: non-adder codes never raise carry or overflow
    a_r6_logic_no_cv: assert property (@(posedge clk) disable iff (rst)
        (alu_op >= 5'd7) |-> (!flag_c && !flag_v));

endmodule

// File: tb/regalu_datapath_test.sv
`timescale 1ns/1ps
module regalu_datapath_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dst_sel = '0, src_a_sel = '0, src_b_sel = '0;
    logic       reg_we = 1'b0, mem_we = 1'b0, wb_from_mem = 1'b0;
    logic [4:0] alu_op = 5'd31;
    logic [7:0] rd_a, rd_b, alu_res, wb_data;
    logic       flag_v, flag_c, flag_n, flag_z;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    regalu_datapath #(.W(8), .NREGS(4)) uut (
        .clk(clk), .rst(rst), .dst_sel(dst_sel), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .reg_we(reg_we), .alu_op(alu_op),
        .mem_we(mem_we), .wb_from_mem(wb_from_mem), .rd_a(rd_a), .rd_b(rd_b),
        .alu_res(alu_res), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n),
        .flag_z(flag_z), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] f;
        logic [3:0] vcnz;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VECS [NVEC] = '{
        '{5'd2,  8'h7F, 8'h01, 8'h80, 4'b1010},  // R5 add overflow
        '{5'd2,  8'hFF, 8'h01, 8'h00, 4'b0101},  // R5 add carry, zero
        '{5'd3,  8'h10, 8'h20, 8'h31, 4'b0000},  // R5 add plus one
        '{5'd5,  8'h05, 8'h05, 8'h00, 4'b0101},  // R5 subtract equal
        '{5'd5,  8'h03, 8'h05, 8'hFE, 4'b0010},  // R5 subtract negative
        '{5'd5,  8'h80, 8'h01, 8'h7F, 4'b1100},  // R5 subtract overflow
        '{5'd4,  8'h0A, 8'h03, 8'h06, 4'b0100},  // R5 add inverted B
        '{5'd1,  8'hFF, 8'h00, 8'h00, 4'b0101},  // R5 increment wrap
        '{5'd1,  8'h7F, 8'h00, 8'h80, 4'b1010},  // R5 increment overflow
        '{5'd6,  8'h00, 8'h00, 8'hFF, 4'b0010},  // R5 decrement zero
        '{5'd6,  8'h80, 8'h00, 8'h7F, 4'b1100},  // R5 decrement overflow
        '{5'd0,  8'h9C, 8'h11, 8'h9C, 4'b0010},  // R5 transfer A
        '{5'd7,  8'h12, 8'h00, 8'h00, 4'b0001},  // R6 transfer B
        '{5'd8,  8'hF0, 8'h3C, 8'h30, 4'b0000},  // R6 and
        '{5'd9,  8'hF0, 8'h0C, 8'hFC, 4'b0010},  // R6 or
        '{5'd10, 8'hAA, 8'hAA, 8'h00, 4'b0001},  // R6 xor
        '{5'd11, 8'h0F, 8'h00, 8'hF0, 4'b0010},  // R6 not A
        '{5'd12, 8'h00, 8'h81, 8'h40, 4'b0000},  // R6 shift right
        '{5'd13, 8'h00, 8'h81, 8'h02, 4'b0000},  // R6 shift left
        '{5'd14, 8'h00, 8'h00, 8'h00, 4'b0000},  // R8 unused code
        '{5'd31, 8'h55, 8'h66, 8'h00, 4'b0000}   // R8 unused code
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // build a constant with zero, shift-left and increment
    task automatic load_const(input logic [1:0] r, input logic [7:0] val);
        @(negedge clk);
        dst_sel = r; reg_we = 1'b1; wb_from_mem = 1'b0; mem_we = 1'b0;
        alu_op = 5'd31;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            src_b_sel = r; alu_op = 5'd13;
            if (val[i]) begin
                @(negedge clk);
                src_a_sel = r; alu_op = 5'd1;
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] r, output logic [7:0] v);
        src_a_sel = r;
        #1;
        v = rd_a;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register
        for (int r = 0; r < 4; r++) begin
            read_reg(2'(r), v);
            chk("R1 reset value", v, 8'h00);
        end

        // R5 R6 R7 R8: ALU vector table
        for (int k = 0; k < NVEC; k++) begin
            load_const(2'd0, VECS[k].a);
            load_const(2'd1, VECS[k].b);
            src_a_sel = 2'd0; src_b_sel = 2'd1; alu_op = VECS[k].op;
            #1;
            chk($sformatf("R5/R6/R8 result op=%0d", VECS[k].op), alu_res, VECS[k].f);
            chk($sformatf("R5/R6/R7/R8 flags vcnz op=%0d", VECS[k].op),
                {4'h0, flag_v, flag_c, flag_n, flag_z}, {4'h0, VECS[k].vcnz});
        end

        // R3: independent ports and same register on both
        load_const(2'd2, 8'h5A);
        load_const(2'd3, 8'hC3);
        src_a_sel = 2'd2; src_b_sel = 2'd3; #1;
        chk("R3 port A", rd_a, 8'h5A);
        chk("R3 port B", rd_b, 8'hC3);
        src_a_sel = 2'd3; #1;
        chk("R3 same register on both ports", rd_a, rd_b);

        // R2: disabled write leaves the target alone
        @(negedge clk);
        dst_sel = 2'd2; src_b_sel = 2'd3; alu_op = 5'd7; reg_we = 1'b0;
        @(negedge clk);
        read_reg(2'd2, v);
        chk("R2 no write without enable", v, 8'h5A);

        // R4: read during write shows old then new
        @(negedge clk);
        src_a_sel = 2'd2; dst_sel = 2'd2; src_b_sel = 2'd3; alu_op = 5'd7; reg_we = 1'b1;
        #1;
        chk("R4 old value during write", rd_a, 8'h5A);
        @(negedge clk);
        reg_we = 1'b0; #1;
        chk("R4 new value after edge", rd_a, 8'hC3);
        chk("R2 write lands", rd_a, 8'hC3);

        // R9 R10: store 0x77 at 0x10 then load it back
        load_const(2'd0, 8'h10);
        load_const(2'd1, 8'h77);
        @(negedge clk);
        src_a_sel = 2'd0; src_b_sel = 2'd1; mem_we = 1'b1;
        @(negedge clk);
        mem_we = 1'b0; wb_from_mem = 1'b1; #1;
        chk("R9 store then combinational read", wb_data, 8'h77);
        chk("R10 memory source", wb_data, 8'h77);
        wb_from_mem = 1'b0; alu_op = 5'd1; #1;
        chk("R10 ALU source", wb_data, 8'h11);
        // R9: store disabled with other data, word unchanged
        src_b_sel = 2'd0;
        @(negedge clk);
        wb_from_mem = 1'b1; #1;
        chk("R9 no store without enable", wb_data, 8'h77);
        // R9: store at another address leaves 0x10 intact
        load_const(2'd2, 8'h11);
        load_const(2'd3, 8'h33);
        @(negedge clk);
        src_a_sel = 2'd2; src_b_sel = 2'd3; mem_we = 1'b1;
        @(negedge clk);
        mem_we = 1'b0; wb_from_mem = 1'b1; #1;
        chk("R9 second address", wb_data, 8'h33);
        src_a_sel = 2'd0; #1;
        chk("R9 first address intact", wb_data, 8'h77);
        // R2 R10: memory writeback into a register
        dst_sel = 2'd1; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; wb_from_mem = 1'b0;
        read_reg(2'd1, v);
        chk("R10 loaded word reaches register", v, 8'h77);

        // R11: reset keeps memory, clears registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_reg(2'd3, v);
        chk("R1 reset clears after use", v, 8'h00);
        load_const(2'd0, 8'h10);
        src_a_sel = 2'd0; wb_from_mem = 1'b1; #1;
        chk("R11 memory survives reset", wb_data, 8'h77);
        wb_from_mem = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule